// File: doc/BRIEF.md
# Hot-Swap Status and Device Hiding Controller

This block keeps the status and control state that a hot-pluggable bus bridge needs while a board is inserted or removed. Two sticky flags record insertion and extraction events reported by hardware. Software clears them by writing ones. A read-only pending flag summarises whether a plug or unplug operation is in progress. An active-low enumeration interrupt tells the host that a flag is set, and a mask bit can silence it.

The block can also hide the device from the buses. Hiding needs four things at once: software has armed it, the hot-swap mode strap is low, the board's ejector switch reads open, and the LED-on control bit is set. When all four hold, the controller waits for any bus cycle already in progress to finish. It then drops a bus-enable output, which keeps the bridge's protocol engines from starting or answering cycles on either side. The bridge stays hidden until the switch closes again. The switch input comes from outside the clock domain and passes through a synchronizer before any logic uses it.

Top module: `hotswap_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `enum_n` is 1 and `bus_en` is 1.
- R2: Register bit 7 (insert flag) and bit 6 (extract flag) are set by a one-cycle pulse on `ins_evt` or `ext_evt`. A write with a 1 in that bit clears the flag, and a write with a 0 leaves it unchanged. A set and a clear in the same cycle leave the flag at 1. The new value can be read one clock edge after the pulse or write.
- R3: Register bit 2 (pending) reads 1 when the insert flag is 1, the extract flag is 1 or `ins_armed` is 1, and reads 0 otherwise. Writes to bit 2 have no effect.
- R4: When register bit 1 (interrupt mask) is 0, `enum_n` is 0 exactly when the insert flag or the extract flag is set.
- R5: When the interrupt mask is 1, `enum_n` stays 1 whatever the two flags hold.
- R6: Bits 0 (hide arm), 1 (interrupt mask) and 3 (LED on) are read/write. Bits 4 and 5 always read 0.
- R7: Hiding starts only when the hide arm is 1, `hs_mode_n` is 0, the synchronized `lstat` is 1 and LED on is 1. If any of these is missing, `bus_en` stays 1.
- R8: Once hiding has started, `bus_en` stays 1 as long as `cyc_busy` is 1. It drops to 0 at the first clock edge that sees `cyc_busy` at 0.
- R9: While hidden, `bus_en` stays 0 even if the hide arm is cleared. It returns to 1 on the third clock edge after `lstat` goes low.
- R10: If `lstat` goes low while the block is still waiting for a bus cycle to finish, the block goes back to normal operation and `bus_en` never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ins_evt | input | 1 | Insertion event pulse |
| ext_evt | input | 1 | Extraction event pulse |
| ins_armed | input | 1 | Insertion sequence armed |
| hs_mode_n | input | 1 | Hot-swap mode strap, active low |
| lstat | input | 1 | Ejector switch, 1 = open (asynchronous) |
| cyc_busy | input | 1 | A bus cycle is in progress |
| bus_en | output | 1 | Bridge may initiate and respond to cycles |
| enum_n | output | 1 | Enumeration interrupt, active low |

## Verification
The hardest state to reach from the ports is a switch that goes low during the drain wait. Reaching it needs the strap, the arm bit and the LED bit all set up first. Then `lstat` has to rise while `cyc_busy` is held high, and fall again before `cyc_busy` is released. The bench drives exactly that sequence. It releases `cyc_busy` only after the synchronizer delay has passed, and it checks `bus_en` on every cycle to catch a brief drop. A second collision, a flag set and a write-one clear in the same cycle, is hit both in a directed step and by the random phase, which compares every cycle against a bench model.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int REG_W     = 8;
  localparam int B_ARM     = 0;
  localparam int B_MASK    = 1;
  localparam int B_PEND    = 2;
  localparam int B_LED     = 3;
  localparam int B_EXT     = 6;
  localparam int B_INS     = 7;

  typedef enum logic [1:0] {
    HS_NORMAL = 2'd0,
    HS_DRAIN  = 2'd1,
    HS_HIDDEN = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_csr.sv
module hs_csr
  import hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ins_set,
  input  logic             ext_set,
  input  logic             ins_armed,
  output logic [REG_W-1:0] rdata,
  output logic             ins_flag,
  output logic             ext_flag,
  output logic             irq_mask,
  output logic             hide_arm,
  output logic             led_on
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[5:4], wdata[B_PEND]};

  // sticky flags: hardware set has priority over write-one clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      if (ins_set)                   ins_flag <= 1'b1;
      else if (wr && wdata[B_INS])   ins_flag <= 1'b0;
      if (ext_set)                   ext_flag <= 1'b1;
      else if (wr && wdata[B_EXT])   ext_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask <= 1'b0;
      hide_arm <= 1'b0;
      led_on   <= 1'b0;
    end else if (wr) begin
      irq_mask <= wdata[B_MASK];
      hide_arm <= wdata[B_ARM];
      led_on   <= wdata[B_LED];
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[B_ARM]  = hide_arm;
    rdata[B_MASK] = irq_mask;
    rdata[B_PEND] = ins_flag | ext_flag | ins_armed;
    rdata[B_LED]  = led_on;
    rdata[B_EXT]  = ext_flag;
    rdata[B_INS]  = ins_flag;
  end

  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ins_set |=> ins_flag);
  a_r2_ext_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ext_set |=> ext_flag);
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[B_INS] && !ins_set) |=> !ins_flag);
endmodule

// File: rtl/hs_hide_fsm.sv
module hs_hide_fsm
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hide_ok,
  input  logic sw_open,
  input  logic busy,
  output logic bus_en
);
  hs_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      HS_NORMAL: if (hide_ok && sw_open) state_nx = HS_DRAIN;
      HS_DRAIN:  if (!sw_open)           state_nx = HS_NORMAL;
                 else if (!busy)         state_nx = HS_HIDDEN;
      HS_HIDDEN: if (!sw_open)           state_nx = HS_NORMAL;
      default:                           state_nx = HS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= HS_NORMAL;
    else        state <= state_nx;
  end

  assign bus_en = (state != HS_HIDDEN);

  a_r8_hidden_via_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_HIDDEN) |-> ($past(state) == HS_DRAIN || $past(state) == HS_HIDDEN));
  a_r8_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_DRAIN && busy && sw_open) |=> (state == HS_DRAIN));
  a_r9_exit_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_HIDDEN && !sw_open) |=> (state == HS_NORMAL));
  a_r10_abort_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_DRAIN && !sw_open) |=> (state == HS_NORMAL));
endmodule

// File: rtl/hotswap_ctrl.sv
module hotswap_ctrl
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ins_evt,
  input  logic             ext_evt,
  input  logic             ins_armed,
  input  logic             hs_mode_n,
  input  logic             lstat,
  input  logic             cyc_busy,
  output logic             bus_en,
  output logic             enum_n
);
  logic ins_flag, ext_flag, irq_mask, hide_arm, led_on, sw_open, hide_ok;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lstat), .q(sw_open)
  );

  hs_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .ins_set(ins_evt), .ext_set(ext_evt), .ins_armed(ins_armed),
    .rdata(reg_rdata), .ins_flag(ins_flag), .ext_flag(ext_flag),
    .irq_mask(irq_mask), .hide_arm(hide_arm), .led_on(led_on)
  );

  assign hide_ok = hide_arm && !hs_mode_n && led_on;

  hs_hide_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hide_ok(hide_ok), .sw_open(sw_open),
    .busy(cyc_busy), .bus_en(bus_en)
  );

  assign enum_n = !((ins_flag || ext_flag) && !irq_mask);

  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[B_MASK] |-> enum_n);
  a_r4_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[B_MASK] && (reg_rdata[B_INS] || reg_rdata[B_EXT])) |-> !enum_n);
  a_r7_no_hide_strap: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode_n && bus_en) |=> bus_en);
endmodule

// File: tb/hotswap_ctrl_bench.sv
`timescale 1ns/1ps
module hotswap_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0; logic [7:0] reg_wdata = 0; logic [7:0] reg_rdata;
  logic ins_evt = 0, ext_evt = 0, ins_armed = 0, hs_mode_n = 1, lstat = 0, cyc_busy = 0;
  logic bus_en, enum_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hotswap_ctrl u_hotswap_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ins_evt(ins_evt), .ext_evt(ext_evt),
    .ins_armed(ins_armed), .hs_mode_n(hs_mode_n), .lstat(lstat),
    .cyc_busy(cyc_busy), .bus_en(bus_en), .enum_n(enum_n)
  );

  // model state
  logic m_ins = 0, m_ext = 0, m_mask = 0, m_arm = 0, m_led = 0;

  function automatic logic [7:0] exp_reg(logic i, logic e, logic armd, logic l, logic mk, logic ar);
    return {i, e, 2'b00, l, (i | e | armd), mk, ar};
  endfunction

  function automatic logic exp_enum(logic i, logic e, logic mk);
    return !((i | e) & !mk);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 reg", reg_rdata, 8'h00);
    chk("R1 enum_n", {7'd0, enum_n}, 8'h01);
    chk("R1 bus_en", {7'd0, bus_en}, 8'h01);
    rst_n = 1; tick();

    // directed R2 set beats clear in same cycle
    ins_evt = 1; reg_wr = 1; reg_wdata = 8'h80; tick(); ins_evt = 0; reg_wr = 0;
    chk("R2 set wins", reg_rdata & 8'h80, 8'h80);
    chk("R4 enum on ins", {7'd0, enum_n}, 8'h00);
    wr(8'h00);
    chk("R2 write0 keeps", reg_rdata & 8'h80, 8'h80);
    wr(8'h80);
    chk("R2 w1c", reg_rdata & 8'h80, 8'h00);
    // R6 readonly/reserved bits ignore writes
    wr(8'h3f);
    chk("R6 rw bits", reg_rdata, 8'h0b);
    chk("R5 masked", {7'd0, enum_n}, 8'h01);
    wr(8'h00);

    // random phase: strap high so hiding never engages (R7)
    for (int n = 0; n < 3000; n++) begin
      logic ie, ee, w; logic [7:0] d;
      ie = ($urandom % 8) == 0; ee = ($urandom % 8) == 0; w = ($urandom % 3) == 0;
      d = 8'($urandom);
      ins_evt = ie; ext_evt = ee; reg_wr = w; reg_wdata = d;
      ins_armed = ($urandom % 4) == 0; lstat = 1'($urandom);
      cyc_busy = 1'($urandom); hs_mode_n = 1;
      if (ie) m_ins = 1; else if (w && d[7]) m_ins = 0;
      if (ee) m_ext = 1; else if (w && d[6]) m_ext = 0;
      if (w) begin m_mask = d[1]; m_arm = d[0]; m_led = d[3]; end
      tick();
      chk("R2/R3/R6 reg", reg_rdata, exp_reg(m_ins, m_ext, ins_armed, m_led, m_mask, m_arm));
      chk("R4/R5 enum_n", {7'd0, enum_n}, {7'd0, exp_enum(m_ins, m_ext, m_mask)});
      chk("R7 strap blocks", {7'd0, bus_en}, 8'h01);
    end
    ins_evt = 0; ext_evt = 0; reg_wr = 0; ins_armed = 0; lstat = 0; cyc_busy = 0;
    wr(8'hc0); tick(4);
    chk("R3 pending clear", reg_rdata & 8'h04, 8'h00);

    // R7 LED off blocks hiding
    hs_mode_n = 0; wr(8'h01); lstat = 1;
    for (int k = 0; k < 8; k++) begin tick(); chk("R7 led off", {7'd0, bus_en}, 8'h01); end
    lstat = 0; tick(4);

    // R8 drain then hide
    wr(8'h09); cyc_busy = 1; lstat = 1;
    for (int k = 0; k < 10; k++) begin tick(); chk("R8 drain holds", {7'd0, bus_en}, 8'h01); end
    cyc_busy = 0; tick();
    chk("R8 hidden", {7'd0, bus_en}, 8'h00);
    // R9 clearing arm does not release
    wr(8'h00); tick(3);
    chk("R9 stays hidden", {7'd0, bus_en}, 8'h00);
    lstat = 0; tick(2);
    chk("R9 sync delay", {7'd0, bus_en}, 8'h00);
    tick();
    chk("R9 released", {7'd0, bus_en}, 8'h01);

    // R10 switch closes during drain
    wr(8'h09); cyc_busy = 1; lstat = 1; tick(6);
    lstat = 0;
    for (int k = 0; k < 10; k++) begin
      if (k == 3) cyc_busy = 0;
      tick(); chk("R10 no hide", {7'd0, bus_en}, 8'h01);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule